// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from a set of sources and presents one interrupt line to a single processor. The sources are external wires, pulses from internal timers, and four doorbells that software raises by writing a register. Each source owns a configuration word with a mask, a sense setting, a 4-bit priority and a vector number. The line to the processor rises whenever the best waiting source has a priority strictly above both a programmable task threshold and the priority of the interrupt already being serviced.

Software handles an interrupt by reading an acknowledge register. That read returns the winning source's vector and moves the source onto an in-service stack. If no source qualifies, the read returns a programmable spurious vector instead. A write to the end-of-interrupt register pops the stack, so a lower-priority source can then be presented. All registers sit on a simple 32-bit bus, and read data comes back one cycle after the request. A configuration bit marks source 0 as the input from a downstream controller.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq` is low. Task priority reads 0 and the spurious vector reads 0xFF. Every source word at 0x40+4*i reads 0x8000_0000 with the source index i in the vector field.
- R2: A source whose word has bit 31 (mask) set is never signalled and never acknowledged. An edge or doorbell latched while masked is delivered once the mask is cleared.
- R3: `irq` is high exactly when a pending, unmasked, not-in-service source has a priority above the task priority and above the top in-service priority. A source that has been acknowledged no longer drives `irq`.
- R4: An acknowledge read at 0x0C returns the vector (source word bits 7:0) of the highest-priority qualifying source. Equal priorities go to the lowest source index. The source is pushed onto the in-service stack.
- R5: An acknowledge read with no qualifying source returns the spurious vector. The spurious vector is written at 0x04, bits 7:0.
- R6: Any write to 0x10 pops the in-service stack, so the next source can be presented. Such a write with an empty stack has no effect.
- R7: While a source is in service, only a strictly higher priority can be acknowledged. Equal or lower priorities wait for the end-of-interrupt write.
- R8: For external sources, bit 22 set selects level sense and bit 22 clear selects edge sense. Bit 23 set means active-high or rising, and bit 23 clear means active-low or falling. A level request that goes away before acknowledge is dropped. An edge request is held until it is acknowledged.
- R9: Timer sources (indices 4..5) latch on a one-cycle event pulse whatever their sense bits. Doorbell n (source 6+n) latches on a write at 0x20+4*n with bit 0 = 1. A write with bit 0 = 0 has no effect.
- R10: The task priority register at 0x08 keeps write bits 3:0. A source is signalled only when its priority is strictly greater than this value.
- R11: Configuration bit 29 at 0x00 is readable. When it is set, source 0 is treated as level-sensitive, active-high, whatever its own sense bits.
- R12: Every read request returns its data with `busRvalid` high one cycle later. A source word reads back its mask, sense, priority and vector fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Bus request strobe, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address (word aligned) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRvalid |
| busRvalid | output | 1 | Read data valid, one cycle after a read request |
| extIrq | input | NUM_EXT | External interrupt lines |
| tmrEvt | input | NUM_TMR | Internal timer event pulses |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A corrupted pending latch or source word shows at the ports in one of two ways. Either `irq` is asserted while no qualifying source should exist, or the next acknowledge read returns the wrong vector. `irq` shows the fault within two cycles of the cause. A stack that fails to push or to pop changes which source a later acknowledge is allowed to take. Such a fault therefore shows as a spurious vector where a real one belongs, or the reverse, on the very next acknowledge. The bench checks the nesting order, tie-breaking, masking and the two sense modes through acknowledge values and the level of `irq`.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int SRC_IDX_W = 6;
  localparam int PRIO_W    = 4;
  localparam int VEC_W     = 8;
  localparam int NUM_DB    = 4;
  localparam int DATA_W    = 32;

  // field positions inside a source word and the configuration word
  localparam int MASK_BIT    = 31;
  localparam int POL_BIT     = 23;
  localparam int LVL_BIT     = 22;
  localparam int PRIO_LSB    = 16;
  localparam int CASCADE_BIT = 29;

  // word offsets (byte address / 4)
  localparam int W_CFG  = 0;
  localparam int W_SPUR = 1;
  localparam int W_TASK = 2;
  localparam int W_ACK  = 3;
  localparam int W_EOI  = 4;
  localparam int W_DB   = 8;
  localparam int W_VP   = 16;

  typedef struct packed {
    logic                  vpWe;
    logic [SRC_IDX_W-1:0]  vpIdx;
    logic                  wMask;
    logic                  wPol;
    logic                  wLvl;
    logic [PRIO_W-1:0]     wPrio;
    logic [VEC_W-1:0]      wVec;
    logic [NUM_DB-1:0]     dbSet;
    logic                  ackTake;
    logic [SRC_IDX_W-1:0]  ackIdx;
  } ctl_strobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_EXT = 4,
  parameter int NUM_TMR = 2,
  localparam int NSRC   = NUM_EXT + NUM_TMR + NUM_DB
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_strobe_t          strb,
  input  logic                 cascadeEn,
  input  logic [NUM_EXT-1:0]   extIrq,
  input  logic [NUM_TMR-1:0]   tmrEvt,
  input  logic [NSRC-1:0]      inService,
  input  logic [SRC_IDX_W-1:0] vpRdIdx,
  output logic [DATA_W-1:0]    vpRdata,
  output logic                 bestValid,
  output logic [SRC_IDX_W-1:0] bestIdx,
  output logic [PRIO_W-1:0]    bestPrio,
  output logic [VEC_W-1:0]     bestVec
);

  logic [NSRC-1:0]   maskQ, polQ, lvlQ, rawPend, eligible;
  logic [PRIO_W-1:0] prioQ [NSRC];
  logic [VEC_W-1:0]  vecQ  [NSRC];

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    logic selWr, ackHit;
    assign selWr  = strb.vpWe && (strb.vpIdx == SRC_IDX_W'(gi));
    assign ackHit = strb.ackTake && (strb.ackIdx == SRC_IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ[gi] <= 1'b1;
        polQ[gi]  <= 1'b0;
        lvlQ[gi]  <= 1'b0;
        prioQ[gi] <= '0;
        vecQ[gi]  <= VEC_W'(gi);
      end else if (selWr) begin
        maskQ[gi] <= strb.wMask;
        polQ[gi]  <= strb.wPol;
        lvlQ[gi]  <= strb.wLvl;
        prioQ[gi] <= strb.wPrio;
        vecQ[gi]  <= strb.wVec;
      end
    end

    if (gi < NUM_EXT) begin : g_ext
      logic inQ, inPrev, edgeQ, effLvl, effPol, edgeSeen;
      if (gi == 0) begin : g_casc
        assign effLvl = lvlQ[gi] | cascadeEn;
        assign effPol = polQ[gi] | cascadeEn;
      end else begin : g_plain
        assign effLvl = lvlQ[gi];
        assign effPol = polQ[gi];
      end
      assign edgeSeen = effPol ? (inQ & ~inPrev) : (~inQ & inPrev);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          inQ    <= 1'b0;
          inPrev <= 1'b0;
          edgeQ  <= 1'b0;
        end else begin
          inQ    <= extIrq[gi];
          inPrev <= inQ;
          if (effLvl)        edgeQ <= 1'b0;
          else if (edgeSeen) edgeQ <= 1'b1;
          else if (ackHit)   edgeQ <= 1'b0;
        end
      end
      assign rawPend[gi] = effLvl ? (effPol ? inQ : ~inQ) : edgeQ;

      // R8: a latched edge is only dropped by its acknowledge or a switch to level sense
      p_edge_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
        $fell(edgeQ) |-> ($past(ackHit) || $past(effLvl)));
    end else begin : g_int
      logic evt, pendQ;
      if (gi < NUM_EXT + NUM_TMR) begin : g_tmr
        assign evt = tmrEvt[gi-NUM_EXT];
      end else begin : g_db
        assign evt = strb.dbSet[gi-NUM_EXT-NUM_TMR];
      end
      always_ff @(posedge clk) begin
        if (!rstN)       pendQ <= 1'b0;
        else if (evt)    pendQ <= 1'b1;
        else if (ackHit) pendQ <= 1'b0;
      end
      assign rawPend[gi] = pendQ;
    end
  end

  assign eligible = rawPend & ~maskQ & ~inService;

  // highest priority wins, strict compare keeps the lowest index on ties
  always_comb begin
    bestValid = 1'b0;
    bestIdx   = '0;
    bestPrio  = '0;
    bestVec   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (eligible[i] && (!bestValid || prioQ[i] > bestPrio)) begin
        bestValid = 1'b1;
        bestIdx   = SRC_IDX_W'(i);
        bestPrio  = prioQ[i];
        bestVec   = vecQ[i];
      end
    end
  end

  always_comb begin
    vpRdata = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (vpRdIdx == SRC_IDX_W'(i)) begin
        vpRdata[MASK_BIT]             = maskQ[i];
        vpRdata[POL_BIT]              = polQ[i];
        vpRdata[LVL_BIT]              = lvlQ[i];
        vpRdata[PRIO_LSB +: PRIO_W]   = prioQ[i];
        vpRdata[VEC_W-1:0]            = vecQ[i];
      end
    end
  end

  logic bestMasked, bestBusy;
  always_comb begin
    bestMasked = 1'b0;
    bestBusy   = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (bestIdx == SRC_IDX_W'(i)) begin
        bestMasked = maskQ[i];
        bestBusy   = inService[i];
      end
    end
  end

  // R2: the arbitration winner never carries a set mask bit
  p_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    bestValid |-> !bestMasked);
  // R3: a source already in service is never offered again
  p_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    bestValid |-> !bestBusy);

endmodule

// File: rtl/irq_control.sv
module irq_control
  import prio_irq_pkg::*;
#(
  parameter int NSRC     = 10,
  parameter int ADDR_W   = 8,
  parameter int IS_DEPTH = 16,
  localparam int DEPTH_W = $clog2(IS_DEPTH + 1),
  localparam int WORD_W  = ADDR_W - 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busReq,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busRvalid,
  input  logic                 bestValid,
  input  logic [SRC_IDX_W-1:0] bestIdx,
  input  logic [PRIO_W-1:0]    bestPrio,
  input  logic [VEC_W-1:0]     bestVec,
  input  logic [DATA_W-1:0]    vpRdata,
  output ctl_strobe_t          strb,
  output logic [SRC_IDX_W-1:0] vpRdIdx,
  output logic                 cascadeEn,
  output logic [NSRC-1:0]      inService,
  output logic                 irq
);

  logic [WORD_W-1:0]    wordAddr, vpOff;
  logic                 rd, wr, isVp, ackRd, ackTake, eoiWr, qualify;
  logic [PRIO_W-1:0]    taskQ, curPrio, prevPrio;
  logic [VEC_W-1:0]     spurQ;
  logic                 cascadeQ, irqQ, rvalidQ;
  logic [DATA_W-1:0]    rdataQ, rdMux;
  logic [DEPTH_W-1:0]   depth;
  logic [SRC_IDX_W-1:0] stIdx  [IS_DEPTH];
  logic [PRIO_W-1:0]    stPrio [IS_DEPTH];

  assign wordAddr = busAddr[ADDR_W-1:2];
  assign rd       = busReq && !busWe;
  assign wr       = busReq && busWe;
  assign isVp     = (int'(wordAddr) >= W_VP) && (int'(wordAddr) < W_VP + NSRC);
  assign vpOff    = wordAddr - WORD_W'(W_VP);
  assign vpRdIdx  = SRC_IDX_W'(vpOff);

  // priorities of the top two in-service entries
  always_comb begin
    curPrio  = '0;
    prevPrio = '0;
    for (int k = 0; k < IS_DEPTH; k++) begin
      if (depth == DEPTH_W'(k + 1)) curPrio  = stPrio[k];
      if (depth == DEPTH_W'(k + 2)) prevPrio = stPrio[k];
    end
  end

  always_comb begin
    inService = '0;
    for (int k = 0; k < IS_DEPTH; k++) begin
      for (int s = 0; s < NSRC; s++) begin
        if ((DEPTH_W'(k) < depth) && (stIdx[k] == SRC_IDX_W'(s))) inService[s] = 1'b1;
      end
    end
  end

  assign qualify = bestValid && (bestPrio > taskQ) &&
                   ((depth == '0) || (bestPrio > curPrio)) &&
                   (depth < DEPTH_W'(IS_DEPTH));
  assign ackRd   = rd && (wordAddr == WORD_W'(W_ACK));
  assign ackTake = ackRd && qualify;
  assign eoiWr   = wr && (wordAddr == WORD_W'(W_EOI)) && (depth != '0);

  always_comb begin
    strb.vpWe    = wr && isVp;
    strb.vpIdx   = vpRdIdx;
    strb.wMask   = busWdata[MASK_BIT];
    strb.wPol    = busWdata[POL_BIT];
    strb.wLvl    = busWdata[LVL_BIT];
    strb.wPrio   = busWdata[PRIO_LSB +: PRIO_W];
    strb.wVec    = busWdata[VEC_W-1:0];
    for (int n = 0; n < NUM_DB; n++)
      strb.dbSet[n] = wr && (wordAddr == WORD_W'(W_DB + n)) && busWdata[0];
    strb.ackTake = ackTake;
    strb.ackIdx  = bestIdx;
  end

  always_comb begin
    rdMux = '0;
    if (ackRd)                               rdMux = ackTake ? DATA_W'(bestVec) : DATA_W'(spurQ);
    else if (isVp)                           rdMux = vpRdata;
    else if (wordAddr == WORD_W'(W_CFG))     rdMux[CASCADE_BIT] = cascadeQ;
    else if (wordAddr == WORD_W'(W_SPUR))    rdMux = DATA_W'(spurQ);
    else if (wordAddr == WORD_W'(W_TASK))    rdMux = DATA_W'(taskQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      taskQ    <= '0;
      spurQ    <= '1;
      cascadeQ <= 1'b0;
      irqQ     <= 1'b0;
      rvalidQ  <= 1'b0;
      rdataQ   <= '0;
      depth    <= '0;
      for (int k = 0; k < IS_DEPTH; k++) begin
        stIdx[k]  <= '0;
        stPrio[k] <= '0;
      end
    end else begin
      irqQ    <= qualify && !ackTake;
      rvalidQ <= rd;
      if (rd) rdataQ <= rdMux;
      if (wr && (wordAddr == WORD_W'(W_TASK))) taskQ    <= busWdata[PRIO_W-1:0];
      if (wr && (wordAddr == WORD_W'(W_SPUR))) spurQ    <= busWdata[VEC_W-1:0];
      if (wr && (wordAddr == WORD_W'(W_CFG)))  cascadeQ <= busWdata[CASCADE_BIT];
      if (ackTake) begin
        for (int k = 0; k < IS_DEPTH; k++) begin
          if (depth == DEPTH_W'(k)) begin
            stIdx[k]  <= bestIdx;
            stPrio[k] <= bestPrio;
          end
        end
        depth <= depth + 1'b1;
      end else if (eoiWr) begin
        depth <= depth - 1'b1;
      end
    end
  end

  assign busRdata  = rdataQ;
  assign busRvalid = rvalidQ;
  assign cascadeEn = cascadeQ;
  assign irq       = irqQ;

  // R7: the in-service stack never grows past its depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEPTH_W'(IS_DEPTH));
  // R7: nested entries have strictly rising priority
  p_nest_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    (depth >= DEPTH_W'(2)) |-> (curPrio > prevPrio));
  // R4: a taken acknowledge pushes exactly one entry
  p_push_r4: assert property (@(posedge clk) disable iff (!rstN)
    ackTake |=> (depth == $past(depth) + 1'b1));
  // R6: an end-of-interrupt on a non-empty stack pops one entry
  p_pop_r6: assert property (@(posedge clk) disable iff (!rstN)
    eoiWr |=> (depth == $past(depth) - 1'b1));
  // R12: read data is flagged valid one cycle after the request
  p_rvalid_r12: assert property (@(posedge clk) disable iff (!rstN)
    rd |=> busRvalid);
  // R3: the request line drops right after its source is acknowledged
  p_irq_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    ackTake |=> !irq);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_EXT  = 4,
  parameter int NUM_TMR  = 2,
  parameter int ADDR_W   = 8,
  parameter int IS_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReq,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               busRvalid,
  input  logic [NUM_EXT-1:0] extIrq,
  input  logic [NUM_TMR-1:0] tmrEvt,
  output logic               irq
);
  localparam int NSRC = NUM_EXT + NUM_TMR + NUM_DB;

  ctl_strobe_t          strb;
  logic                 cascadeEn, bestValid;
  logic [NSRC-1:0]      inService;
  logic [SRC_IDX_W-1:0] vpRdIdx, bestIdx;
  logic [PRIO_W-1:0]    bestPrio;
  logic [VEC_W-1:0]     bestVec;
  logic [DATA_W-1:0]    vpRdata;

  irq_control #(.NSRC(NSRC), .ADDR_W(ADDR_W), .IS_DEPTH(IS_DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid),
    .bestValid(bestValid), .bestIdx(bestIdx), .bestPrio(bestPrio), .bestVec(bestVec),
    .vpRdata(vpRdata), .strb(strb), .vpRdIdx(vpRdIdx), .cascadeEn(cascadeEn),
    .inService(inService), .irq(irq)
  );

  irq_datapath #(.NUM_EXT(NUM_EXT), .NUM_TMR(NUM_TMR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cascadeEn(cascadeEn),
    .extIrq(extIrq), .tmrEvt(tmrEvt), .inService(inService), .vpRdIdx(vpRdIdx),
    .vpRdata(vpRdata), .bestValid(bestValid), .bestIdx(bestIdx),
    .bestPrio(bestPrio), .bestVec(bestVec)
  );
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic [3:0]  extIrq = 4'b0010;
  logic [1:0]  tmrEvt = '0;
  logic        irq;

  int total = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid),
    .extIrq(extIrq), .tmrEvt(tmrEvt), .irq(irq)
  );

  // {write, address, data or expected read value}
  localparam int NTBL = 45;
  localparam logic [40:0] TBL [NTBL] = '{
    {1'b0, 8'h40, 32'h8000_0000},  // R1 source 0 reset word
    {1'b0, 8'h64, 32'h8000_0009},  // R1 source 9 reset word
    {1'b0, 8'h08, 32'h0000_0000},  // R1 task priority
    {1'b0, 8'h04, 32'h0000_00FF},  // R1 spurious vector
    {1'b0, 8'h0C, 32'h0000_00FF},  // R5 nothing pending
    {1'b1, 8'h58, 32'h0005_0031},
    {1'b1, 8'h5C, 32'h0005_0032},
    {1'b1, 8'h60, 32'h0009_0033},
    {1'b1, 8'h64, 32'h8009_0034},
    {1'b1, 8'h2C, 32'h0000_0001},
    {1'b1, 8'h24, 32'h0000_0001},
    {1'b1, 8'h20, 32'h0000_0001},
    {1'b0, 8'h0C, 32'h0000_0031},  // R4 tie goes to lower index
    {1'b0, 8'h0C, 32'h0000_00FF},  // R7 equal priority blocked
    {1'b1, 8'h28, 32'h0000_0001},
    {1'b0, 8'h0C, 32'h0000_0033},  // R7 higher priority nests
    {1'b1, 8'h10, 32'h0000_0000},
    {1'b1, 8'h10, 32'h0000_0000},
    {1'b0, 8'h0C, 32'h0000_0032},  // R6 next source after pops
    {1'b1, 8'h10, 32'h0000_0000},
    {1'b0, 8'h0C, 32'h0000_00FF},  // R2 masked doorbell hidden
    {1'b1, 8'h64, 32'h0009_0034},
    {1'b0, 8'h0C, 32'h0000_0034},  // R2 latched while masked, delivered
    {1'b1, 8'h10, 32'h0000_0000},
    {1'b1, 8'h08, 32'h0000_0007},
    {1'b0, 8'h08, 32'h0000_0007},  // R10 task readback
    {1'b1, 8'h20, 32'h0000_0001},
    {1'b0, 8'h0C, 32'h0000_00FF},  // R10 priority 5 under task 7
    {1'b1, 8'h08, 32'h0000_0014},
    {1'b0, 8'h08, 32'h0000_0004},  // R10 only low four bits kept
    {1'b0, 8'h0C, 32'h0000_0031},  // R10 priority 5 over task 4
    {1'b1, 8'h10, 32'h0000_0000},
    {1'b1, 8'h04, 32'h0000_005A},
    {1'b0, 8'h0C, 32'h0000_005A},  // R5 programmed spurious
    {1'b1, 8'h20, 32'h0000_0002},
    {1'b0, 8'h0C, 32'h0000_005A},  // R9 doorbell write with bit0 clear ignored
    {1'b1, 8'h00, 32'h2000_0000},
    {1'b0, 8'h00, 32'h2000_0000},  // R11 config readback
    {1'b1, 8'h00, 32'h0000_0000},
    {1'b1, 8'h10, 32'h0000_0000},
    {1'b1, 8'h24, 32'h0000_0001},
    {1'b0, 8'h0C, 32'h0000_0032},  // R6 empty-stack EOI had no effect
    {1'b1, 8'h10, 32'h0000_0000},
    {1'b1, 8'h08, 32'h0000_0000},
    {1'b0, 8'h58, 32'h0005_0031}   // R12 source word readback
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata; v = busRvalid;
    busReq = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      fails++; total++;
      $display("FAIL watchdog actual %0d expected below 50000 cycles", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic        vld;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    chk("R1 irq after reset", 32'(irq), 32'd0);
    chk("R12 rvalid idle", 32'(busRvalid), 32'd0);

    for (int t = 0; t < NTBL; t++) begin
      if (TBL[t][40]) busWrite(TBL[t][39:32], TBL[t][31:0]);
      else begin
        busRead(TBL[t][39:32], rv, vld);
        chk($sformatf("table entry %0d", t), rv, TBL[t][31:0]);
      end
    end
    chk("R12 rvalid after read", 32'(vld), 32'd1);

    // R8 level, active low on source 1 (priority 2)
    busWrite(8'h44, 32'h0042_0041);
    waitCyc(4);
    chk("R8 level idle", 32'(irq), 32'd0);
    extIrq[1] = 1'b0;
    waitCyc(4);
    chk("R8 level active low raises irq", 32'(irq), 32'd1);
    extIrq[1] = 1'b1;
    waitCyc(4);
    chk("R8 level dropped not latched", 32'(irq), 32'd0);
    extIrq[1] = 1'b0;
    waitCyc(4);
    busRead(8'h0C, rv, vld);
    chk("R4 ack level source", rv, 32'h41);
    waitCyc(3);
    chk("R3 irq low while in service", 32'(irq), 32'd0);
    extIrq[1] = 1'b1;
    busWrite(8'h10, 32'h0);
    busWrite(8'h44, 32'h8042_0041);

    // R8 rising edge on source 2 (priority 3)
    busWrite(8'h48, 32'h0083_0042);
    @(negedge clk) extIrq[2] = 1'b1;
    @(negedge clk) extIrq[2] = 1'b0;
    waitCyc(4);
    chk("R8 edge latched", 32'(irq), 32'd1);
    busRead(8'h0C, rv, vld);
    chk("R8 ack edge source", rv, 32'h42);
    waitCyc(3);
    chk("R3 irq low after ack", 32'(irq), 32'd0);
    busWrite(8'h10, 32'h0);
    waitCyc(4);
    chk("R8 edge consumed by ack", 32'(irq), 32'd0);

    // R9 / R10 timer source 4, sense bits set but ignored, priority 6
    busWrite(8'h50, 32'h00C6_0044);
    busWrite(8'h08, 32'h6);
    @(negedge clk) tmrEvt[0] = 1'b1;
    @(negedge clk) tmrEvt[0] = 1'b0;
    waitCyc(4);
    chk("R10 equal to task not signalled", 32'(irq), 32'd0);
    busWrite(8'h08, 32'h5);
    waitCyc(4);
    chk("R10 above task signalled", 32'(irq), 32'd1);
    busRead(8'h0C, rv, vld);
    chk("R9 timer pulse latched", rv, 32'h44);
    busWrite(8'h10, 32'h0);
    busWrite(8'h08, 32'h0);

    // R11 cascade: source 0 set for falling edge, priority 2
    busWrite(8'h40, 32'h0002_0040);
    @(negedge clk) extIrq[0] = 1'b1;
    waitCyc(4);
    chk("R11 rising ignored without cascade", 32'(irq), 32'd0);
    busWrite(8'h00, 32'h2000_0000);
    waitCyc(4);
    chk("R11 cascade forces active-high level", 32'(irq), 32'd1);
    busRead(8'h0C, rv, vld);
    chk("R11 ack cascade source", rv, 32'h40);
    extIrq[0] = 1'b0;
    busWrite(8'h10, 32'h0);
    waitCyc(4);
    chk("R11 level gone after release", 32'(irq), 32'd0);
    busWrite(8'h00, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule